// File: doc/BRIEF.md
# Buffered PWM duty comparator

This block turns a shared time-base count into one active-high PWM output for a single channel. Software, or a control loop, writes a new duty value into a holding buffer at any time. The block copies that buffer into the active compare register only at a period boundary, so a pulse in progress is never cut short or stretched by a write that lands mid-period.

The time base runs in one of four modes, given on `mode`:

- 0: free-running, edge-aligned.
- 1: single-shot, edge-aligned.
- 2: up/down, center-aligned.
- 3: up/down center-aligned with double update.

The time base provides the count, the period value and two one-cycle strobes:

- `zero_stb` is high in the cycle where the count is zero.
- `match_stb` is high in the cycle where the count equals the period.

In the edge-aligned modes, each period starts with the output active, and the output drops when the count reaches the duty value. In the up/down modes, the output is active while the count is below the duty value. This makes the pulse straddle the count-zero point. In double-update mode, the buffer is also taken at the period-match point, so the rising half and the falling half of a pulse can use different duty values. The duty register is one bit wider than the period, which lets a duty value sit above the period.

Top module: `pwm_duty_cmp`

## Requirements
- R1: After reset the active duty value and the duty buffer are both zero. The output is low, and it stays low after enabling if no duty value has been written.
- R2: Timing and the period-start rule for edge-aligned modes. `pwm_out` is registered: its value in the cycle after a rising clock edge reflects the inputs sampled at that edge. In modes 0 and 1, when the count is zero and the active duty value is nonzero, the output goes active.
- R3: In modes 0 and 1, when the count equals a nonzero active duty value that is not above the period, the output goes inactive. Otherwise the output holds its level within the period.
- R4: An active duty value of zero keeps the output inactive for the whole period, in every mode.
- R5: An active duty value greater than the period keeps the output active for the whole period, in every mode.
- R6: A write on `duty_wr` changes only the buffer. The active value takes the buffer content at `match_stb` in modes 0 and 1, and at `zero_stb` in modes 2 and 3. The active value changes nowhere else while the block is enabled.
- R7: In mode 3 the buffer is also copied into the active value at `match_stb`. Values written during the rising and the falling halves therefore give asymmetric pulses.
- R8: In modes 2 and 3, the output is active exactly when the count is below the active duty value.
- R9: Behaviour while disabled (`en` low):
  - The output is inactive.
  - The active duty value follows the buffer every cycle.
  - The edge-aligned level state is cleared.
- R10: A write in the same cycle as a copy point goes to the buffer only. The active value takes the buffer content from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Time base enabled |
| mode | input | 2 | 0 free-run, 1 single-shot, 2 up/down, 3 up/down double update |
| count | input | CNT_W | Time-base count |
| period | input | CNT_W | Period value |
| zero_stb | input | 1 | High in the cycle the count is zero |
| match_stb | input | 1 | High in the cycle the count equals the period |
| duty_wr | input | 1 | Write strobe for the duty buffer |
| duty_wdata | input | CNT_W+1 | Duty value to write |
| pwm_out | output | 1 | Active-high PWM output |

## Verification
The bench targets a write arriving mid-period. A design that latched it at once would produce a truncated or lengthened pulse in the very period of the write. It also drives duty values of zero, exactly the period, and one above the period. A design that compared with the wrong inequality would leave a glitch of one count, or drop the output at the period count, when it should stay high throughout.

Two cases depend on the order of the copy. In the first, a write lands in the same cycle as the copy point; a design that forwarded the written value would move the new duty one period early. In the second, mode 3 writes a different value in each half of the count. Here a design without the second copy point would produce symmetric pulses.

The bench also drops `en` in the middle of a pulse. A design that failed to clear the held edge level would resume with a stale high output.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;

    typedef enum logic [1:0] {
        MODE_FREE     = 2'd0,
        MODE_ONESHOT  = 2'd1,
        MODE_UPDN     = 2'd2,
        MODE_UPDN_DBL = 2'd3
    } pwm_mode_e;

    function automatic logic mode_is_edge(input pwm_mode_e m);
        return (m == MODE_FREE) || (m == MODE_ONESHOT);
    endfunction

    function automatic logic mode_is_dbl(input pwm_mode_e m);
        return m == MODE_UPDN_DBL;
    endfunction

endpackage

// File: rtl/pwm_duty_buf.sv
module pwm_duty_buf
    import pwm_cmp_pkg::*;
#(
    parameter int DUTY_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  pwm_mode_e         mode,
    input  logic              zero_stb,
    input  logic              match_stb,
    input  logic              wr,
    input  logic [DUTY_W-1:0] wdata,
    output logic [DUTY_W-1:0] duty_buf,
    output logic [DUTY_W-1:0] duty_act
);

    logic take;

    // Copy point: every cycle while disabled, otherwise at the mode's boundary.
    always_comb begin
        if (!en)
            take = 1'b1;
        else if (mode_is_edge(mode))
            take = match_stb;
        else
            take = zero_stb | (mode_is_dbl(mode) & match_stb);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_buf <= '0;
            duty_act <= '0;
        end else begin
            if (wr)
                duty_buf <= wdata;
            if (take)
                duty_act <= duty_buf;
        end
    end

endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen #(
    parameter int CNT_W = 15,
    localparam int DUTY_W = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  period,
    input  logic [DUTY_W-1:0] duty,
    output logic              lvl_next
);

    logic              lvl_q;
    logic [DUTY_W-1:0] cnt_x;
    logic [DUTY_W-1:0] per_x;

    assign cnt_x = {1'b0, count};
    assign per_x = {1'b0, period};

    always_comb begin
        if (!en)
            lvl_next = 1'b0;
        else if (duty == '0)
            lvl_next = 1'b0;
        else if (duty > per_x)
            lvl_next = 1'b1;
        else if (count == '0)
            lvl_next = 1'b1;
        else if (cnt_x == duty)
            lvl_next = 1'b0;
        else
            lvl_next = lvl_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            lvl_q <= 1'b0;
        else
            lvl_q <= lvl_next;
    end

endmodule

// File: rtl/pwm_center_gen.sv
module pwm_center_gen #(
    parameter int CNT_W = 15,
    localparam int DUTY_W = CNT_W + 1
) (
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  period,
    input  logic [DUTY_W-1:0] duty,
    output logic              lvl
);

    logic full;
    logic below;

    assign full  = duty > {1'b0, period};
    assign below = {1'b0, count} < duty;
    assign lvl   = full | below;

endmodule

// File: rtl/pwm_duty_cmp.sv
module pwm_duty_cmp
    import pwm_cmp_pkg::*;
#(
    parameter int CNT_W = 15,
    localparam int DUTY_W = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [1:0]        mode,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  period,
    input  logic              zero_stb,
    input  logic              match_stb,
    input  logic              duty_wr,
    input  logic [DUTY_W-1:0] duty_wdata,
    output logic              pwm_out
);

    pwm_mode_e         mode_e;
    logic [DUTY_W-1:0] duty_buf;
    logic [DUTY_W-1:0] duty_act;
    logic              edge_nxt;
    logic              ctr_lvl;
    logic              sel_lvl;

    assign mode_e = pwm_mode_e'(mode);

    pwm_duty_buf #(.DUTY_W(DUTY_W)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .mode     (mode_e),
        .zero_stb (zero_stb),
        .match_stb(match_stb),
        .wr       (duty_wr),
        .wdata    (duty_wdata),
        .duty_buf (duty_buf),
        .duty_act (duty_act)
    );

    pwm_edge_gen #(.CNT_W(CNT_W)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .count   (count),
        .period  (period),
        .duty    (duty_act),
        .lvl_next(edge_nxt)
    );

    pwm_center_gen #(.CNT_W(CNT_W)) u_ctr (
        .count (count),
        .period(period),
        .duty  (duty_act),
        .lvl   (ctr_lvl)
    );

    assign sel_lvl = mode_is_edge(mode_e) ? edge_nxt : ctr_lvl;

    always_ff @(posedge clk) begin
        if (rst)
            pwm_out <= 1'b0;
        else
            pwm_out <= en & sel_lvl;
    end

endmodule

// File: rtl/pwm_duty_cmp_chk.sv
module pwm_duty_cmp_chk #(
    parameter int CNT_W = 15,
    localparam int DUTY_W = CNT_W + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic [1:0]        mode,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  period,
    input logic              zero_stb,
    input logic              match_stb,
    input logic [DUTY_W-1:0] duty_buf,
    input logic [DUTY_W-1:0] duty_act,
    input logic              pwm_out
);

    logic is_edge;
    assign is_edge = (mode == 2'd0) || (mode == 2'd1);

    p_edge_start_r2: assert property (@(posedge clk) disable iff (rst)
        (en && is_edge && count == '0 && duty_act != '0) |=> pwm_out);

    p_edge_stop_r3: assert property (@(posedge clk) disable iff (rst)
        (en && is_edge && duty_act != '0 && duty_act <= {1'b0, period}
         && {1'b0, count} == duty_act) |=> !pwm_out);

    p_zero_duty_r4: assert property (@(posedge clk) disable iff (rst)
        (en && duty_act == '0) |=> !pwm_out);

    p_full_duty_r5: assert property (@(posedge clk) disable iff (rst)
        (en && duty_act > {1'b0, period}) |=> pwm_out);

    p_edge_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (en && is_edge && !match_stb) |=> $stable(duty_act));

    p_updn_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (en && !is_edge && !zero_stb && !(mode == 2'd3 && match_stb))
        |=> $stable(duty_act));

    p_center_r8: assert property (@(posedge clk) disable iff (rst)
        (en && !is_edge) |=> (pwm_out == $past({1'b0, count} < duty_act)));

    p_off_low_r9: assert property (@(posedge clk) disable iff (rst)
        !en |=> !pwm_out);

    p_off_follow_r9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (duty_act == $past(duty_buf)));

endmodule

bind pwm_duty_cmp pwm_duty_cmp_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .mode     (mode),
    .count    (count),
    .period   (period),
    .zero_stb (zero_stb),
    .match_stb(match_stb),
    .duty_buf (duty_buf),
    .duty_act (duty_act),
    .pwm_out  (pwm_out)
);

// File: tb/sim_pwm_duty_cmp.sv
module sim_pwm_duty_cmp;

    localparam int CW = 15;
    localparam int DW = CW + 1;
    localparam int P  = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [CW-1:0] count = '0;
    logic [CW-1:0] period = CW'(P);
    logic          zero_stb = 1'b0;
    logic          match_stb = 1'b0;
    logic          duty_wr = 1'b0;
    logic [DW-1:0] duty_wdata = '0;
    logic          pwm_out;

    always #10 clk = ~clk;

    pwm_duty_cmp #(.CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .en(en), .mode(mode), .count(count),
        .period(period), .zero_stb(zero_stb), .match_stb(match_stb),
        .duty_wr(duty_wr), .duty_wdata(duty_wdata), .pwm_out(pwm_out)
    );

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    string tag = "R1";

    // reference model state
    int m_buf = 0, m_act = 0;
    bit m_edge = 0, m_out = 0;

    task automatic step(input bit r, input bit e, input int md, input int cnt,
                        input bit z, input bit m, input bit w, input int wd);
        bit lvl, ctr, take;
        int act_n, buf_n;
        rst = r; en = e; mode = md[1:0]; count = cnt[CW-1:0];
        zero_stb = z; match_stb = m; duty_wr = w; duty_wdata = wd[DW-1:0];
        if (r) begin
            lvl = 0; act_n = 0; buf_n = 0; m_out = 0;
        end else begin
            if (!e)                lvl = 0;
            else if (m_act == 0)   lvl = 0;
            else if (m_act > P)    lvl = 1;
            else if (cnt == 0)     lvl = 1;
            else if (cnt == m_act) lvl = 0;
            else                   lvl = m_edge;
            ctr = (m_act > P) || (cnt < m_act);
            m_out = e && ((md < 2) ? lvl : ctr);
            if (!e)          take = 1;
            else if (md < 2) take = m;
            else             take = z || (md == 3 && m);
            act_n = take ? m_buf : m_act;
            buf_n = w ? wd : m_buf;
        end
        m_edge = lvl; m_act = act_n; m_buf = buf_n;
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (pwm_out !== m_out) begin
            errors++;
            $display("FAIL %s cnt=%0d mode=%0d actual=%b expected=%b",
                     tag, cnt, md, pwm_out, m_out);
        end
    endtask

    task automatic edge_period(input int md, input int wr_at, input int wd);
        for (int c = 0; c <= P; c++)
            step(0, 1, md, c, c == 0, c == P, c == wr_at, wd);
    endtask

    task automatic updn_period(input int md, input int up_at, input int upv,
                               input int dn_at, input int dnv);
        for (int c = 0; c <= P; c++)
            step(0, 1, md, c, c == 0, c == P, c == up_at, upv);
        for (int c = P - 1; c >= 1; c--)
            step(0, 1, md, c, 0, 0, c == dn_at, dnv);
    endtask

    task automatic off_cycles(input int n, input int md, input bit w, input int wd);
        for (int i = 0; i < n; i++)
            step(0, 0, md, 0, 0, 0, w && i == 0, wd);
    endtask

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, 0, 0);
        tag = "R1";
        checks++;
        if (pwm_out !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset actual=%b expected=0", pwm_out);
        end
        edge_period(0, -1, 0);
        edge_period(0, -1, 0);

        tag = "R9"; off_cycles(3, 0, 1, 4);
        tag = "R2 R3"; edge_period(0, -1, 0); edge_period(0, -1, 0);
        tag = "R6"; edge_period(0, 3, 7); edge_period(0, -1, 0);
        tag = "R3 duty=P"; edge_period(0, 2, P); edge_period(0, -1, 0);
        tag = "R4"; edge_period(0, 5, 0); edge_period(0, -1, 0);
        tag = "R5"; edge_period(0, 1, P + 1); edge_period(0, -1, 0);
        tag = "R10"; edge_period(0, P, 3); edge_period(0, -1, 0); edge_period(0, -1, 0);
        tag = "R2 oneshot"; edge_period(1, 4, 6); edge_period(1, -1, 0);
        step(0, 1, 1, 0, 1, 0, 0, 0); step(0, 1, 1, 1, 0, 0, 0, 0);
        tag = "R9 mid-pulse"; off_cycles(3, 1, 0, 0);
        tag = "R9 restart"; edge_period(0, -1, 0);

        tag = "R9"; off_cycles(2, 2, 1, 5);
        tag = "R8"; updn_period(2, -1, 0, -1, 0); updn_period(2, -1, 0, -1, 0);
        tag = "R6 updn"; updn_period(2, 3, 2, -1, 0); updn_period(2, -1, 0, 4, 8);
        updn_period(2, -1, 0, -1, 0);
        tag = "R4 updn"; updn_period(2, 2, 0, -1, 0); updn_period(2, -1, 0, -1, 0);
        tag = "R5 updn"; updn_period(2, 2, P + 1, -1, 0); updn_period(2, -1, 0, -1, 0);
        tag = "R7"; updn_period(3, 2, 6, 5, 3); updn_period(3, 2, 1, 4, 7);
        updn_period(3, -1, 0, -1, 0); updn_period(3, -1, 0, -1, 0);
        tag = "R10 dbl"; updn_period(3, P, 2, -1, 0); updn_period(3, -1, 0, -1, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog all requirements actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule